// File: doc/BRIEF.md
# Boundary-Scan Test Port with System-Reset Pin Override

This block is a boundary-scan test access port for a device that has a small, parameterised set of bidirectional bus pins. It contains the sixteen-state controller, which is stepped by TMS on rising TCK. It also holds an 8-bit instruction register and three selectable data registers: a boundary register with three cells per pin, a 32-bit identification register and a single bypass bit. The instruction decoder covers BYPASS, SAMPLE/PRELOAD, EXTEST, CLAMP, HIGHZ and IDCODE. The block steers each pin's data and output enable either from the core logic or from the boundary register's update stage.

An active-low system reset input sits outside the control of the test logic. While it is low, every pin in a parameter-selected group is forced to high impedance, whatever the instruction or the boundary cells request. While it is high, the pins follow the test logic exactly. The pad drivers and the core function are outside the block. The block receives the core's data and enable per pin and hands finished data and enable values to the pads.

Top module: `tap_pinmux`

## Requirements
- R1: While trst_n is low, or after TMS has been high on five consecutive rising TCK edges, the controller is in Test-Logic-Reset. In that state the active instruction becomes IDCODE (opcode 0x02), so a following data scan returns the identification value and the pins carry core data and enable.
- R2: Capture-IR loads the instruction shift register with 8'b0000_0001. The register shifts toward TDO least significant bit first, and Update-IR makes the shifted value the active instruction.
- R3: Under IDCODE the data path is the 32-bit ID_VAL constant, whose bit 0 must be 1, shifted out least significant bit first.
- R4: Opcode 0xFF and every opcode from 0x05 to 0xFE select the bypass bit. That bit captures 0 and delays TDI by one shift.
- R5: Under SAMPLE/PRELOAD (0x01) the pins carry core data and enable. Capture-DR loads boundary bit 3i with pad_in[i], bit 3i+1 with pad_out[i] and bit 3i+2 with pad_oe[i]. Bit 0 is shifted out first. Update-DR preloads the update stage without moving the pins.
- R6: Under EXTEST (0x00) pin i is driven with data from update bit 3i+1 and enable from update bit 3i+2. The update stage changes only on leaving Update-DR, so the pins hold still while new data shifts.
- R7: Under CLAMP (0x03) the pins keep the update-stage values while the bypass bit sits between TDI and TDO.
- R8: Under HIGHZ (0x04) every pad_oe is 0 and the bypass bit sits between TDI and TDO.
- R9: While sys_rst_n is low, pad_oe[i] is 0 for every pin whose RST_GRP bit is 1, under any instruction. Pins outside the group, and all pins while sys_rst_n is high, follow R5 to R8.
- R10: TDO changes only on falling TCK. tdo_en is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| tdo_en | output | 1 | TDO drive enable, high while shifting |
| sys_rst_n | input | 1 | Active-low system reset, forces the pin group to high impedance |
| core_out | input | NPIN | Core data per pin |
| core_oe | input | NPIN | Core output enable per pin |
| pad_in | input | NPIN | Level seen at each pin |
| pad_out | output | NPIN | Data to each pad driver |
| pad_oe | output | NPIN | Output enable to each pad driver |

## Verification
The hardest situation to reach is a clash between the system reset and boundary cells that ask for drive. To get there, an enable pattern with ones in the group pins must first be preloaded and then made active under EXTEST or CLAMP, through several complete instruction and data scans, before sys_rst_n drops. The bench preloads random patterns under SAMPLE/PRELOAD and promotes them through EXTEST to CLAMP. It then pulls the system reset low with ones in the enable cells and checks that only the group pins go to high impedance. Pin stability while a scan is in progress is checked on every shift cycle of each random EXTEST scan.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [2:0] {
      IN_BYPASS, IN_EXTEST, IN_SAMPLE, IN_IDCODE, IN_CLAMP, IN_HIGHZ
   } tap_instr_e;

   typedef enum logic [1:0] {
      DS_BYPASS, DS_BOUNDARY, DS_IDENT
   } tap_dsel_e;

   localparam int unsigned CELLS_PER_PIN = 3;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e state_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state_q <= ST_RESET;
      else         state_q <= tap_next(state_q, tms);
   end

   assign state = state_q;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int unsigned IR_W = 8
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic            ir_lsb,
   output logic [IR_W-1:0] ir_shift,
   output tap_instr_e      instr,
   output tap_dsel_e       dsel
);

   localparam logic [IR_W-1:0] OP_EXTEST  = IR_W'(0);
   localparam logic [IR_W-1:0] OP_SAMPLE  = IR_W'(1);
   localparam logic [IR_W-1:0] OP_IDCODE  = IR_W'(2);
   localparam logic [IR_W-1:0] OP_CLAMP   = IR_W'(3);
   localparam logic [IR_W-1:0] OP_HIGHZ   = IR_W'(4);
   localparam logic [IR_W-1:0] CAP_PATTERN = IR_W'(1);

   logic [IR_W-1:0] sh_q;
   logic [IR_W-1:0] act_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh_q  <= CAP_PATTERN;
         act_q <= OP_IDCODE;
      end else begin
         case (state)
            ST_RESET:  act_q <= OP_IDCODE;
            ST_CAP_IR: sh_q  <= CAP_PATTERN;
            ST_SH_IR:  sh_q  <= {tdi, sh_q[IR_W-1:1]};
            ST_UPD_IR: act_q <= sh_q;
            default: ;
         endcase
      end
   end

   always_comb begin
      if      (act_q == OP_EXTEST) instr = IN_EXTEST;
      else if (act_q == OP_SAMPLE) instr = IN_SAMPLE;
      else if (act_q == OP_IDCODE) instr = IN_IDCODE;
      else if (act_q == OP_CLAMP)  instr = IN_CLAMP;
      else if (act_q == OP_HIGHZ)  instr = IN_HIGHZ;
      else                         instr = IN_BYPASS;
   end

   always_comb begin
      case (instr)
         IN_EXTEST, IN_SAMPLE: dsel = DS_BOUNDARY;
         IN_IDCODE:            dsel = DS_IDENT;
         default:              dsel = DS_BYPASS;
      endcase
   end

   assign ir_lsb   = sh_q[0];
   assign ir_shift = sh_q;

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter int unsigned       NPIN   = 4,
   parameter logic [31:0]       ID_VAL = 32'h0000_0001,
   localparam int unsigned      BSR_LEN = CELLS_PER_PIN * NPIN,
   localparam int unsigned      UPD_LEN = 2 * NPIN
) (
   input  logic               tck,
   input  logic               trst_n,
   input  tap_state_e         state,
   input  logic               tdi,
   input  tap_dsel_e          dsel,
   input  logic [BSR_LEN-1:0] cap_vec,
   output logic               dr_lsb,
   output logic               byp_bit,
   output logic [UPD_LEN-1:0] upd_vec
);

   logic               byp_q;
   logic [31:0]        id_q;
   logic [BSR_LEN-1:0] bsr_q;
   logic [UPD_LEN-1:0] upd_q;
   logic [UPD_LEN-1:0] upd_src;

   // bypass bit
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) byp_q <= 1'b0;
      else if (dsel == DS_BYPASS) begin
         if (state == ST_CAP_DR)     byp_q <= 1'b0;
         else if (state == ST_SH_DR) byp_q <= tdi;
      end
   end

   // identification shift register
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) id_q <= ID_VAL;
      else if (dsel == DS_IDENT) begin
         if (state == ST_CAP_DR)     id_q <= ID_VAL;
         else if (state == ST_SH_DR) id_q <= {tdi, id_q[31:1]};
      end
   end

   // boundary shift stage
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) bsr_q <= '0;
      else if (dsel == DS_BOUNDARY) begin
         if (state == ST_CAP_DR)     bsr_q <= cap_vec;
         else if (state == ST_SH_DR) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
      end
   end

   // only data and enable cells have an update stage
   for (genvar i = 0; i < NPIN; i++) begin : g_upd_map
      assign upd_src[2*i]   = bsr_q[CELLS_PER_PIN*i+1];
      assign upd_src[2*i+1] = bsr_q[CELLS_PER_PIN*i+2];
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) upd_q <= '0;
      else if (state == ST_UPD_DR && dsel == DS_BOUNDARY) upd_q <= upd_src;
   end

   always_comb begin
      case (dsel)
         DS_BOUNDARY: dr_lsb = bsr_q[0];
         DS_IDENT:    dr_lsb = id_q[0];
         default:     dr_lsb = byp_q;
      endcase
   end

   assign byp_bit = byp_q;
   assign upd_vec = upd_q;

endmodule

// File: rtl/tap_pinmux.sv
module tap_pinmux
   import tap_pkg::*;
#(
   parameter int unsigned      NPIN    = 4,
   parameter int unsigned      IR_W    = 8,
   parameter logic [31:0]      ID_VAL  = 32'h1A5C_3E2B,
   parameter logic [NPIN-1:0]  RST_GRP = NPIN'(3)
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tms,
   input  logic            tdi,
   output logic            tdo,
   output logic            tdo_en,
   input  logic            sys_rst_n,
   input  logic [NPIN-1:0] core_out,
   input  logic [NPIN-1:0] core_oe,
   input  logic [NPIN-1:0] pad_in,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe
);

   localparam int unsigned BSR_LEN = CELLS_PER_PIN * NPIN;
   localparam int unsigned UPD_LEN = 2 * NPIN;

   if (IR_W < 3) begin : g_bad_irw
      $error("IR_W must hold opcode 0x04");
   end
   if (ID_VAL[0] != 1'b1) begin : g_bad_id
      $error("ID_VAL bit 0 must be 1");
   end
   if (NPIN < 1) begin : g_bad_npin
      $error("NPIN must be at least 1");
   end

   tap_state_e         state;
   tap_instr_e         instr;
   tap_dsel_e          dsel;
   logic               ir_lsb;
   logic [IR_W-1:0]    ir_shift;
   logic               dr_lsb;
   logic               byp_bit;
   logic [UPD_LEN-1:0] upd_vec;
   logic [BSR_LEN-1:0] cap_vec;
   logic               tdo_q;
   logic               tdo_en_q;

   tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   tap_ir #(.IR_W(IR_W)) u_ir (
      .tck      (tck),
      .trst_n   (trst_n),
      .state    (state),
      .tdi      (tdi),
      .ir_lsb   (ir_lsb),
      .ir_shift (ir_shift),
      .instr    (instr),
      .dsel     (dsel)
   );

   tap_dr #(.NPIN(NPIN), .ID_VAL(ID_VAL)) u_dr (
      .tck     (tck),
      .trst_n  (trst_n),
      .state   (state),
      .tdi     (tdi),
      .dsel    (dsel),
      .cap_vec (cap_vec),
      .dr_lsb  (dr_lsb),
      .byp_bit (byp_bit),
      .upd_vec (upd_vec)
   );

   // per-pin steering; the system reset override sits after the instruction mux
   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic drv_out;
      logic drv_oe;

      always_comb begin
         case (instr)
            IN_EXTEST, IN_CLAMP: begin
               drv_out = upd_vec[2*i];
               drv_oe  = upd_vec[2*i+1];
            end
            IN_HIGHZ: begin
               drv_out = core_out[i];
               drv_oe  = 1'b0;
            end
            default: begin
               drv_out = core_out[i];
               drv_oe  = core_oe[i];
            end
         endcase
      end

      assign pad_out[i] = drv_out;

      if (RST_GRP[i]) begin : g_forced
         assign pad_oe[i] = drv_oe & sys_rst_n;
      end else begin : g_free
         assign pad_oe[i] = drv_oe;
      end

      assign cap_vec[CELLS_PER_PIN*i]   = pad_in[i];
      assign cap_vec[CELLS_PER_PIN*i+1] = pad_out[i];
      assign cap_vec[CELLS_PER_PIN*i+2] = pad_oe[i];
   end

   // serial output retimed to the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q    <= 1'b0;
         tdo_en_q <= 1'b0;
      end else begin
         tdo_q    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
         tdo_en_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
      end
   end

   assign tdo    = tdo_q;
   assign tdo_en = tdo_en_q;

endmodule

// File: rtl/tap_pinmux_chk.sv
module tap_pinmux_chk
   import tap_pkg::*;
#(
   parameter int unsigned     NPIN    = 4,
   parameter int unsigned     IR_W    = 8,
   parameter logic [NPIN-1:0] RST_GRP = NPIN'(3),
   localparam int unsigned    UPD_LEN = 2 * NPIN
) (
   input logic               tck,
   input logic               trst_n,
   input logic               tms,
   input logic               sys_rst_n,
   input tap_state_e         state,
   input tap_instr_e         instr,
   input tap_dsel_e          dsel,
   input logic [IR_W-1:0]    ir_shift,
   input logic               byp_bit,
   input logic [UPD_LEN-1:0] upd_vec,
   input logic [NPIN-1:0]    pad_oe,
   input logic               tdo_en
);

   logic [2:0] hi_cnt;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)            hi_cnt <= 3'd0;
      else if (!tms)          hi_cnt <= 3'd0;
      else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
   end

   p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_cnt == 3'd5) |-> (state == ST_RESET));

   p_reset_idcode_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET) |=> (instr == IN_IDCODE));

   p_ir_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_IR) |=> (ir_shift == IR_W'(1)));

   p_byp_capture_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_DR && dsel == DS_BYPASS) |=> (byp_bit == 1'b0));

   p_upd_hold_r6: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_UPD_DR) |=> $stable(upd_vec));

   p_highz_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (instr == IN_HIGHZ) |-> (pad_oe == '0));

   p_sysrst_r9: assert property (@(posedge tck) disable iff (!trst_n)
      (!sys_rst_n) |-> ((pad_oe & RST_GRP) == '0));

   p_tdo_en_r10: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en == ((state == ST_SH_IR) || (state == ST_SH_DR)));

endmodule

bind tap_pinmux tap_pinmux_chk #(.NPIN(NPIN), .IR_W(IR_W), .RST_GRP(RST_GRP)) u_chk (
   .tck       (tck),
   .trst_n    (trst_n),
   .tms       (tms),
   .sys_rst_n (sys_rst_n),
   .state     (state),
   .instr     (instr),
   .dsel      (dsel),
   .ir_shift  (ir_shift),
   .byp_bit   (byp_bit),
   .upd_vec   (upd_vec),
   .pad_oe    (pad_oe),
   .tdo_en    (tdo_en)
);

// File: tb/tap_pinmux_tb.sv
module tap_pinmux_tb;

   localparam int unsigned     NPIN    = 4;
   localparam logic [31:0]     ID_VAL  = 32'h1A5C_3E2B;
   localparam logic [NPIN-1:0] RST_GRP = 4'b0110;
   localparam int unsigned     BLEN    = 3 * NPIN;

   logic tck = 1'b0;
   logic trst_n, tms, tdi, sys_rst_n;
   logic tdo, tdo_en;
   logic [NPIN-1:0] core_out, core_oe, pad_in, pad_out, pad_oe;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   always #4 tck = ~tck;

   tap_pinmux #(.NPIN(NPIN), .IR_W(8), .ID_VAL(ID_VAL), .RST_GRP(RST_GRP)) u_dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .sys_rst_n(sys_rst_n), .core_out(core_out), .core_oe(core_oe),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_cap(input logic [NPIN-1:0] pin,
                                           input logic [NPIN-1:0] o,
                                           input logic [NPIN-1:0] e);
      logic [63:0] v = '0;
      for (int i = 0; i < NPIN; i++) begin
         v[3*i]   = pin[i];
         v[3*i+1] = o[i];
         v[3*i+2] = e[i];
      end
      return v;
   endfunction

   function automatic logic [NPIN-1:0] fld_out(input logic [63:0] v);
      logic [NPIN-1:0] r;
      for (int i = 0; i < NPIN; i++) r[i] = v[3*i+1];
      return r;
   endfunction

   function automatic logic [NPIN-1:0] fld_oe(input logic [63:0] v);
      logic [NPIN-1:0] r;
      for (int i = 0; i < NPIN; i++) r[i] = v[3*i+2];
      return r;
   endfunction

   function automatic logic [63:0] exp_byp(input logic [63:0] din, input int n);
      logic [63:0] r = '0;
      for (int i = 1; i < n; i++) r[i] = din[i-1];
      return r;
   endfunction

   task automatic step(input logic m, input logic d, output logic o);
      @(negedge tck);
      #1;
      tms = m;
      tdi = d;
      o   = tdo;
   endtask

   task automatic settle();
      @(negedge tck);
      #1;
   endtask

   // from Run-Test/Idle, full scan, back to Run-Test/Idle
   task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                       output logic [63:0] dout, input bit pin_chk,
                       input logic [NPIN-1:0] e_out, input logic [NPIN-1:0] e_oe);
      logic b;
      dout = '0;
      step(1'b1, 1'b0, b);
      if (is_ir) step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b);
      for (int i = 0; i < n; i++) begin
         step((i == n-1), din[i], b);
         dout[i] = b;
         if (i == 0) chk("R10 tdo_en while shifting", 64'(tdo_en), 64'd1);
         if (pin_chk) begin
            chk("R6 pad_out stable during shift", 64'(pad_out), 64'(e_out));
            chk("R6 pad_oe stable during shift", 64'(pad_oe), 64'(e_oe));
         end
         if (i == 0) begin
            @(posedge tck);
            #1;
            chk("R10 tdo holds across rising edge", 64'(tdo), 64'(b));
         end
      end
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      settle();
   endtask

   task automatic load_ir(input logic [7:0] op);
      logic [63:0] d;
      scan(1'b1, 8, 64'(op), d, 1'b0, '0, '0);
   endtask

   initial begin
      logic [63:0] d, din, pre;
      logic b;
      void'($urandom(32'd20240611));
      trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; sys_rst_n = 1'b1;
      core_out = NPIN'($urandom); core_oe = NPIN'($urandom); pad_in = NPIN'($urandom);
      repeat (3) @(posedge tck);
      settle();
      chk("R1 reset pad_out from core", 64'(pad_out), 64'(core_out));
      chk("R1 reset pad_oe from core", 64'(pad_oe), 64'(core_oe));
      chk("R10 tdo_en low at reset", 64'(tdo_en), 64'd0);
      trst_n = 1'b1;
      step(1'b0, 1'b0, b);
      settle();

      // identification after reset
      scan(1'b0, 32, 64'h0, d, 1'b0, '0, '0);
      chk("R1 R3 idcode after reset", d & 64'hFFFF_FFFF, 64'(ID_VAL));
      chk("R10 tdo_en low in idle", 64'(tdo_en), 64'd0);

      // instruction capture pattern
      scan(1'b1, 8, 64'hFF, d, 1'b0, '0, '0);
      chk("R2 ir capture pattern", d & 64'hFF, 64'h01);

      din = {$urandom, $urandom};
      scan(1'b0, 16, din, d, 1'b0, '0, '0);
      chk("R4 bypass 0xFF", d & 64'hFFFF, exp_byp(din, 16));

      for (int k = 0; k < 5; k++) begin
         logic [7:0] op;
         op = 8'(5 + ($urandom % 250));
         load_ir(op);
         din = {$urandom, $urandom};
         scan(1'b0, 12, din, d, 1'b0, '0, '0);
         chk("R4 undefined opcode bypass", d & 64'hFFF, exp_byp(din, 12));
      end

      // SAMPLE/PRELOAD
      load_ir(8'h01);
      for (int k = 0; k < 6; k++) begin
         core_out = NPIN'($urandom); core_oe = NPIN'($urandom); pad_in = NPIN'($urandom);
         settle();
         chk("R5 sample pins follow core data", 64'(pad_out), 64'(core_out));
         chk("R5 sample pins follow core enable", 64'(pad_oe), 64'(core_oe));
         pre = 64'({$urandom} & ((1 << BLEN) - 1));
         scan(1'b0, BLEN, pre, d, 1'b1, core_out, core_oe);
         chk("R5 sample capture", d & ((64'd1 << BLEN) - 1), exp_cap(pad_in, core_out, core_oe));
         chk("R5 preload leaves pins", 64'(pad_oe), 64'(core_oe));
      end

      // EXTEST
      load_ir(8'h00);
      chk("R6 extest data from update", 64'(pad_out), 64'(fld_out(pre)));
      chk("R6 extest enable from update", 64'(pad_oe), 64'(fld_oe(pre)));
      for (int k = 0; k < 6; k++) begin
         pad_in = NPIN'($urandom);
         settle();
         din = 64'({$urandom} & ((1 << BLEN) - 1));
         if (k == 5) din = din | 64'h924;
         scan(1'b0, BLEN, din, d, 1'b1, fld_out(pre), fld_oe(pre));
         chk("R6 extest capture", d & ((64'd1 << BLEN) - 1),
             exp_cap(pad_in, fld_out(pre), fld_oe(pre)));
         pre = din;
         chk("R6 extest pins after update", 64'(pad_out), 64'(fld_out(pre)));
         chk("R6 extest enable after update", 64'(pad_oe), 64'(fld_oe(pre)));
      end

      // CLAMP
      load_ir(8'h03);
      chk("R7 clamp data", 64'(pad_out), 64'(fld_out(pre)));
      chk("R7 clamp enable", 64'(pad_oe), 64'(fld_oe(pre)));
      din = {$urandom, $urandom};
      scan(1'b0, 10, din, d, 1'b1, fld_out(pre), fld_oe(pre));
      chk("R7 clamp bypass path", d & 64'h3FF, exp_byp(din, 10));

      // system reset against driving enable cells
      sys_rst_n = 1'b0;
      settle();
      chk("R9 group forced off under clamp", 64'(pad_oe), 64'(fld_oe(pre) & ~RST_GRP));
      chk("R9 data untouched under clamp", 64'(pad_out), 64'(fld_out(pre)));
      sys_rst_n = 1'b1;
      settle();
      chk("R9 release restores clamp enable", 64'(pad_oe), 64'(fld_oe(pre)));

      // HIGHZ
      load_ir(8'h04);
      chk("R8 highz enables", 64'(pad_oe), 64'd0);
      din = {$urandom, $urandom};
      scan(1'b0, 9, din, d, 1'b0, '0, '0);
      chk("R8 highz bypass path", d & 64'h1FF, exp_byp(din, 9));

      // TMS-held reset from Shift-DR
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b);
      for (int k = 0; k < 5; k++) step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      settle();
      core_out = NPIN'($urandom); core_oe = '1;
      settle();
      chk("R1 tms reset pins from core", 64'(pad_oe), 64'(core_oe));
      scan(1'b0, 32, 64'h0, d, 1'b0, '0, '0);
      chk("R1 tms reset idcode", d & 64'hFFFF_FFFF, 64'(ID_VAL));

      // system reset in functional mode
      sys_rst_n = 1'b0;
      settle();
      chk("R9 group forced off in functional mode", 64'(pad_oe), 64'(core_oe & ~RST_GRP));
      chk("R9 data path unchanged", 64'(pad_out), 64'(core_out));
      sys_rst_n = 1'b1;
      settle();
      chk("R9 release restores core enable", 64'(pad_oe), 64'(core_oe));

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge tck);
      if (!done) begin
         done = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

endmodule